// File: doc/BRIEF.md
# Physical Address Region Decoder

This block sits between a processor's physical address bus and the targets behind it. Each cycle it looks at the address, the direction and the access size of the current access. It raises exactly one region select, or none. It also produces a second-level select among six on-chip system peripherals and one serial-port sub-select inside the peripheral-control space. The read data from the addressed target is steered onto a single return bus.

Some accesses are screened. A read from a reserved region raises a data abort in the same cycle. A write to a reserved region simply completes with no effect. Writes to ROM are dropped: no select is raised and no error is reported. The memory-configuration and display/DMA regions take only full-word accesses; anything narrower is flagged as a size error and never reaches them. An access to an undefined sub-region of the system-control space reads as zero and sets a sticky debug bit, which stays set until reset.

Top module: `addr_region_decoder`

## Requirements
- R1: Address bits [31:24] choose the primary region. `region_sel` is one-hot or zero, with this bit order: 0 ROM (0x00), 1 card slot A (0x20, 0x21, 0x2E, 0x2F), 2 card slot B (0x30, 0x31, 0x3E, 0x3F), 3 peripheral control (0x80), 4 system control (0x90), 5 memory configuration (0xA0), 6 display/DMA (0xB0), 7 RAM (0xC0 through 0xDF). A RAM read returns `ram_rdata`.
- R2: A ROM read raises bit 0 and returns `rom_rdata`. A ROM write raises no select, no abort and no size error.
- R3: A read from reserved region 0x40, 0x41, 0x7E or 0x7F raises `abort` combinationally in the same cycle, with no select and zero read data.
- R4: A write to a reserved region raises neither `abort` nor any select.
- R5: An access to either card slot raises that slot's select, and a read from it returns zero.
- R6: Inside 0x90, bits [23:16] values 0 to 5 raise bit n of the one-hot `sys_sel`, with the order timer, real-time clock, power manager, reset controller, GPIO, interrupt controller. A read returns slice n of `sys_rdata` (bits n*32 up to n*32+31).
- R7: Inside 0x90, a bits [23:16] value of 6 or more raises no `sys_sel` bit and reads as zero. `unk_sticky` is set from the next clock edge on and stays set until reset.
- R8: Inside 0x80, bits [23:16] = 0x05 raise `uart_sel`, and a read returns `uart_rdata`. Any other sub-region reads as zero.
- R9: Size codes are 00 byte, 01 halfword, 10 word and 11 reserved. An access to 0xA0 or 0xB0 with a size other than 10 raises `size_err`, raises no select and reads as zero. A word access raises the select and returns `memcfg_rdata` or `disp_rdata`.
- R10: Any other primary region is unmapped: no select, no abort, no size error, and reads return zero.
- R11: `abort` is never raised on a write. With `acc_valid` low, every select, `abort`, `size_err` and `rd_data` are zero, and writes always return zero on `rd_data`.
- R12: Reset clears `unk_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| acc_addr | input | 32 | Physical address |
| rom_rdata | input | DATA_W | ROM read data |
| uart_rdata | input | DATA_W | Serial port read data |
| sys_rdata | input | N_SYS*DATA_W | System peripheral read data, slice n for peripheral n |
| memcfg_rdata | input | DATA_W | Memory configuration read data |
| disp_rdata | input | DATA_W | Display/DMA read data |
| ram_rdata | input | DATA_W | RAM read data |
| region_sel | output | 8 | One-hot primary region select |
| sys_sel | output | N_SYS | One-hot system peripheral select |
| uart_sel | output | 1 | Serial port select |
| rd_data | output | DATA_W | Steered read data |
| abort | output | 1 | Data abort on reserved read |
| size_err | output | 1 | Narrow access to a word-only region |
| unk_sticky | output | 1 | Sticky flag for an undefined system sub-region access |

## Verification
The assertions assume that the address, direction, size and valid inputs are steady around each rising edge. They also assume that reset is applied before the first access. The sticky-bit properties depend on that. The bench changes inputs only on the falling edge and applies reset at the start and once more partway through. Random stimulus covers all four size codes, including the reserved one, and sub-region values both inside and outside the defined range. Most addresses are drawn from a list of region boundaries, with a share of fully random ones mixed in.

// File: rtl/addr_region_decoder.sv
`timescale 1ns/1ps
module addr_region_decoder #(
  parameter int DATA_W = 32,
  parameter int N_SYS = 6,
  parameter logic [7:0] UART_SUB = 8'h05,
  parameter logic [7:0] RAM_LO = 8'hC0,
  parameter logic [7:0] RAM_HI = 8'hDF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [1:0]              acc_size,
  input  logic [31:0]             acc_addr,
  input  logic [DATA_W-1:0]       rom_rdata,
  input  logic [DATA_W-1:0]       uart_rdata,
  input  logic [N_SYS*DATA_W-1:0] sys_rdata,
  input  logic [DATA_W-1:0]       memcfg_rdata,
  input  logic [DATA_W-1:0]       disp_rdata,
  input  logic [DATA_W-1:0]       ram_rdata,
  output logic [7:0]              region_sel,
  output logic [N_SYS-1:0]        sys_sel,
  output logic                    uart_sel,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    abort,
  output logic                    size_err,
  output logic                    unk_sticky
);

  localparam logic [1:0] SZ_WORD = 2'b10;

  logic [7:0] top, sub;
  logic rd, is_word;
  logic hit_rom, hit_cda, hit_cdb, hit_rsv, hit_pctl, hit_sctl, hit_mcfg, hit_disp, hit_ram;
  logic sys_unknown;
  logic [DATA_W-1:0] sys_mux;
  logic unused_low;

  assign top        = acc_addr[31:24];
  assign sub        = acc_addr[23:16];
  assign unused_low = ^acc_addr[15:0];
  assign rd         = acc_valid & ~acc_write;
  assign is_word    = (acc_size == SZ_WORD);

  assign hit_rom  = (top == 8'h00);
  assign hit_cda  = (top inside {8'h20, 8'h21, 8'h2E, 8'h2F});
  assign hit_cdb  = (top inside {8'h30, 8'h31, 8'h3E, 8'h3F});
  assign hit_rsv  = (top inside {8'h40, 8'h41, 8'h7E, 8'h7F});
  assign hit_pctl = (top == 8'h80);
  assign hit_sctl = (top == 8'h90);
  assign hit_mcfg = (top == 8'hA0);
  assign hit_disp = (top == 8'hB0);
  assign hit_ram  = (top >= RAM_LO) && (top <= RAM_HI);

  assign region_sel[0] = rd & hit_rom;
  assign region_sel[1] = acc_valid & hit_cda;
  assign region_sel[2] = acc_valid & hit_cdb;
  assign region_sel[3] = acc_valid & hit_pctl;
  assign region_sel[4] = acc_valid & hit_sctl;
  assign region_sel[5] = acc_valid & hit_mcfg & is_word;
  assign region_sel[6] = acc_valid & hit_disp & is_word;
  assign region_sel[7] = acc_valid & hit_ram;

  assign size_err = acc_valid & (hit_mcfg | hit_disp) & ~is_word;
  assign abort    = rd & hit_rsv;
  assign uart_sel = region_sel[3] & (sub == UART_SUB);

  genvar g;
  generate
    for (g = 0; g < N_SYS; g++) begin : g_sys
      assign sys_sel[g] = region_sel[4] & (sub == 8'(g));
    end
  endgenerate

  assign sys_unknown = region_sel[4] & (sub >= 8'(N_SYS));

  always_comb begin
    sys_mux = '0;
    for (int i = 0; i < N_SYS; i++)
      if (sys_sel[i]) sys_mux = sys_mux | sys_rdata[i*DATA_W +: DATA_W];
  end

  always_comb begin
    rd_data = '0;
    if (rd) begin
      if (region_sel[0])      rd_data = rom_rdata;
      else if (uart_sel)      rd_data = uart_rdata;
      else if (region_sel[4]) rd_data = sys_mux;
      else if (region_sel[5]) rd_data = memcfg_rdata;
      else if (region_sel[6]) rd_data = disp_rdata;
      else if (region_sel[7]) rd_data = ram_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           unk_sticky <= 1'b0;
    else if (sys_unknown) unk_sticky <= 1'b1;
  end

endmodule

// File: rtl/addr_region_decoder_chk.sv
`timescale 1ns/1ps
module addr_region_decoder_chk #(
  parameter int DATA_W = 32,
  parameter int N_SYS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [31:0]       acc_addr,
  input logic [7:0]        region_sel,
  input logic [N_SYS-1:0]  sys_sel,
  input logic              uart_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              abort,
  input logic              size_err,
  input logic              unk_sticky
);

  logic rsv_top;
  assign rsv_top = (acc_addr[31:24] == 8'h40) || (acc_addr[31:24] == 8'h41) ||
                   (acc_addr[31:24] == 8'h7E) || (acc_addr[31:24] == 8'h7F);

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel));

  p_rom_wr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr[31:24] == 8'h00) |-> (region_sel == 8'h00 && !abort));

  p_rsv_rd_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && rsv_top) |-> (abort && region_sel == 8'h00 && rd_data == '0));

  p_rsv_wr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && rsv_top) |-> (!abort && region_sel == 8'h00));

  p_sys_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sys_sel) && ((sys_sel != '0) -> region_sel[4]));

  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[31:24] == 8'h90 && acc_addr[23:16] >= 8'(N_SYS)) |=> unk_sticky);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unk_sticky |=> unk_sticky);

  p_uart_in_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uart_sel |-> region_sel[3]);

  p_size_err_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (region_sel[6:5] == 2'b00 && rd_data == '0));

  p_no_wr_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_write |-> !abort);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (region_sel == 8'h00 && !abort && !size_err && rd_data == '0));

endmodule

bind addr_region_decoder addr_region_decoder_chk #(.DATA_W(DATA_W), .N_SYS(N_SYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .region_sel(region_sel), .sys_sel(sys_sel), .uart_sel(uart_sel),
  .rd_data(rd_data), .abort(abort), .size_err(size_err), .unk_sticky(unk_sticky)
);

// File: tb/sim_addr_region_decoder.sv
`timescale 1ns/1ps
module sim_addr_region_decoder;
  localparam int DW = 32;
  localparam int NS = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, acc_valid, acc_write;
  logic [1:0] acc_size;
  logic [31:0] acc_addr;
  logic [DW-1:0] rom_rdata, uart_rdata, memcfg_rdata, disp_rdata, ram_rdata;
  logic [NS*DW-1:0] sys_rdata;
  logic [7:0] region_sel;
  logic [NS-1:0] sys_sel;
  logic uart_sel, abort, size_err, unk_sticky;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_sticky = 1'b0;
  bit finished = 1'b0;

  addr_region_decoder u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .rom_rdata(rom_rdata),
    .uart_rdata(uart_rdata), .sys_rdata(sys_rdata), .memcfg_rdata(memcfg_rdata),
    .disp_rdata(disp_rdata), .ram_rdata(ram_rdata), .region_sel(region_sel),
    .sys_sel(sys_sel), .uart_sel(uart_sel), .rd_data(rd_data), .abort(abort),
    .size_err(size_err), .unk_sticky(unk_sticky)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s addr=%08h wr=%0b sz=%0d v=%0b: actual=%0h expected=%0h",
               req, what, acc_addr, acc_write, acc_size, acc_valid, act, exp);
    end
  endtask

  task automatic model(output string tag, output logic [7:0] e_sel, output logic [NS-1:0] e_sys,
                       output logic e_uart, output logic [DW-1:0] e_rd, output logic e_ab,
                       output logic e_se, output logic e_unk);
    logic [7:0] t, s;
    t = acc_addr[31:24];
    s = acc_addr[23:16];
    e_sel = 8'h00; e_sys = '0; e_uart = 1'b0; e_rd = '0; e_ab = 1'b0; e_se = 1'b0; e_unk = 1'b0;
    tag = "R10";
    case (t)
      8'h00: begin tag = "R2"; if (!acc_write) begin e_sel = 8'h01; e_rd = rom_rdata; end end
      8'h20, 8'h21, 8'h2E, 8'h2F: begin tag = "R5"; e_sel = 8'h02; end
      8'h30, 8'h31, 8'h3E, 8'h3F: begin tag = "R5"; e_sel = 8'h04; end
      8'h40, 8'h41, 8'h7E, 8'h7F: begin
        if (acc_write) tag = "R4"; else begin tag = "R3"; e_ab = 1'b1; end
      end
      8'h80: begin
        tag = "R8"; e_sel = 8'h08;
        if (s == 8'h05) begin e_uart = 1'b1; e_rd = uart_rdata; end
      end
      8'h90: begin
        e_sel = 8'h10;
        if (s < NS) begin tag = "R6"; e_sys[s] = 1'b1; e_rd = sys_rdata[s*DW +: DW]; end
        else begin tag = "R7"; e_unk = 1'b1; end
      end
      8'hA0: begin tag = "R9"; if (acc_size == 2'b10) begin e_sel = 8'h20; e_rd = memcfg_rdata; end else e_se = 1'b1; end
      8'hB0: begin tag = "R9"; if (acc_size == 2'b10) begin e_sel = 8'h40; e_rd = disp_rdata; end else e_se = 1'b1; end
      default: if (t >= 8'hC0 && t <= 8'hDF) begin tag = "R1"; e_sel = 8'h80; e_rd = ram_rdata; end
    endcase
    if (acc_write) e_rd = '0;
    if (!acc_valid) begin
      tag = "R11"; e_sel = 8'h00; e_sys = '0; e_uart = 1'b0; e_rd = '0; e_ab = 1'b0; e_se = 1'b0; e_unk = 1'b0;
    end
  endtask

  task automatic access(input logic v, input logic w, input logic [1:0] sz, input logic [31:0] a);
    string tag;
    logic [7:0] e_sel; logic [NS-1:0] e_sys; logic e_uart, e_ab, e_se, e_unk; logic [DW-1:0] e_rd;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_size = sz; acc_addr = a;
    rom_rdata = $urandom; uart_rdata = $urandom; ram_rdata = $urandom;
    memcfg_rdata = $urandom; disp_rdata = $urandom;
    #1;
    model(tag, e_sel, e_sys, e_uart, e_rd, e_ab, e_se, e_unk);
    chk(tag, "region_sel", 64'(region_sel), 64'(e_sel));
    chk(tag, "sys_sel", 64'(sys_sel), 64'(e_sys));
    chk(tag, "uart_sel", 64'(uart_sel), 64'(e_uart));
    chk(tag, "rd_data", 64'(rd_data), 64'(e_rd));
    chk(w ? "R11" : tag, "abort", 64'(abort), 64'(e_ab));
    chk(tag, "size_err", 64'(size_err), 64'(e_se));
    chk("R7", "unk_sticky", 64'(unk_sticky), 64'(exp_sticky));
    @(posedge clk);
    if (e_unk) exp_sticky = 1'b1;
  endtask

  function automatic logic [7:0] pick_top();
    logic [7:0] lst [0:19];
    lst = '{8'h00, 8'h20, 8'h21, 8'h2E, 8'h2F, 8'h30, 8'h31, 8'h3E, 8'h3F, 8'h40,
            8'h41, 8'h7E, 8'h7F, 8'h80, 8'h90, 8'hA0, 8'hB0, 8'hC0, 8'hDF, 8'hE0};
    if ($urandom_range(3) == 0) return 8'($urandom);
    return lst[$urandom_range(19)];
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) sys_rdata[i*DW +: DW] = 32'h5A00_0000 + 32'(i * 32'h0101);
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_size = 2'b10; acc_addr = 32'h4000_0000;
    rom_rdata = '0; uart_rdata = '0; memcfg_rdata = '0; disp_rdata = '0; ram_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "unk_sticky in reset", 64'(unk_sticky), 64'd0);
    chk("R11", "region_sel idle", 64'(region_sel), 64'd0);
    chk("R11", "abort idle", 64'(abort), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 ROM read and dropped write
    access(1, 0, 2'b10, 32'h0000_1234);
    access(1, 1, 2'b00, 32'h0012_0000);
    // R3 / R4 reserved regions
    access(1, 0, 2'b10, 32'h4000_0000);
    access(1, 0, 2'b00, 32'h41FF_FFFF);
    access(1, 0, 2'b01, 32'h7E00_0010);
    access(1, 0, 2'b10, 32'h7F00_0000);
    access(1, 1, 2'b10, 32'h4000_0000);
    access(1, 1, 2'b00, 32'h7F12_3456);
    // R11 idle with a reserved address
    access(0, 0, 2'b10, 32'h4000_0000);
    // R5 card slots
    access(1, 0, 2'b10, 32'h2000_0000);
    access(1, 1, 2'b10, 32'h2F00_0000);
    access(1, 0, 2'b01, 32'h3E00_0000);
    // R6 every system peripheral, R7 unknown sub-region
    for (int i = 0; i < NS; i++) access(1, 0, 2'b10, 32'h9000_0000 | (32'(i) << 16));
    access(1, 0, 2'b10, 32'h9006_0000);
    access(1, 0, 2'b10, 32'h9000_0000);
    // R8 serial port and another sub-region
    access(1, 0, 2'b10, 32'h8005_0000);
    access(1, 0, 2'b10, 32'h8004_0000);
    // R9 word-only regions
    access(1, 0, 2'b00, 32'hA000_0000);
    access(1, 1, 2'b01, 32'hB000_0004);
    access(1, 0, 2'b11, 32'hA000_0008);
    access(1, 0, 2'b10, 32'hA000_0000);
    access(1, 0, 2'b10, 32'hB000_0000);
    // R1 RAM bounds, R10 unmapped
    access(1, 0, 2'b10, 32'hC000_0000);
    access(1, 0, 2'b10, 32'hDF00_0000);
    access(1, 0, 2'b10, 32'hE000_0000);
    access(1, 0, 2'b10, 32'h1000_0000);
    access(1, 1, 2'b10, 32'hFF00_0000);

    // R12 reset clears the sticky flag
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R12", "unk_sticky after reset", 64'(unk_sticky), 64'd0);
    exp_sticky = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] t, s;
      t = pick_top();
      s = ($urandom_range(1) == 0) ? 8'($urandom_range(7)) : 8'($urandom);
      access($urandom_range(9) != 0, 1'($urandom), 2'($urandom), {t, s, 16'($urandom)});
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all requirements: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule